// File: doc/BRIEF.md
# MMU fault syndrome generator

This block sits between a translation lookup and the exception controller of a processor with virtual memory. For every access it decides whether the address goes through translation or through the identity map. On a successful lookup it forms the physical address. On a failed lookup it records the faulting address and a syndrome code, and it raises an exception request that stays up until the exception controller takes it. The TLB storage and the search are outside the block. It receives only the lookup outcome: hit, fault kind, and the matched virtual and physical bases.

The physical address, the permission bypass flag and the access-good flag are combinational. The syndrome, the captured address, the exception request and the recursive-fault pulse are registered, and they change at the clock edge that ends the faulting access. A second fault that arrives while an exception is still pending is not recorded as a new syndrome. It is flagged as a recursive fault instead.

Top module: `mmu_fault_syndrome`

## Requirements
- R1: Translation is active only when `cfg_mmu_present` and `vm_on` are both 1, and, if `cfg_full` is 1, `cfg_mmu_used` is also 1. Otherwise the access is not translated.
- R2: When translation is inactive, `paddr` equals `vaddr`, `full_perm` is 1 and a valid request never faults. When translation is active, `full_perm` is 0.
- R3: When translation is active and `lu_hit` is 1, the page part of `paddr` equals the page part of `lu_pbase + page_align(vaddr) - lu_vbase`.
- R4: Whenever `xlat_ok` is 1, the low log2(PAGE_BYTES) bits of `paddr` equal those of `vaddr` (default page of 4096 bytes, 12 offset bits).
- R5: A fault is a valid request with translation active and `lu_hit` 0. When no exception is pending, a fault loads `ear` with the full `vaddr` and sets `exc_req` at the same clock edge.
- R6: The syndrome low bits hold 16 for a protection fault (`lu_err_prot`=1) on a non-fetch access, 17 for a protection fault on a fetch, 18 for a miss (`lu_err_prot`=0) on a non-fetch access and 19 for a miss on a fetch. All other syndrome bits except bit 10 are 0.
- R7: The access type `acc` uses 0 for load, 1 for store, 2 for fetch and 3 for load. Syndrome bit 10 is 1 exactly when the faulting access is a store.
- R8: A fault that arrives while `exc_req` is 1 produces a one-cycle `recursive` pulse after the edge and leaves `syndrome` and `ear` unchanged.
- R9: `exc_ack` while `exc_req` is 1, with no new capture, clears `exc_req` at that edge.
- R10: After reset `syndrome`, `ear`, `exc_req` and `recursive` are all 0.
- R11: With `req_valid` 0, a failed lookup raises no exception, changes no captured state and gives `xlat_ok` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| vaddr | input | AW | Virtual address of the access |
| acc | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 load |
| cfg_mmu_present | input | 1 | Configuration: MMU built in |
| cfg_full | input | 1 | Configuration: full configuration set is present |
| cfg_mmu_used | input | 1 | Configuration: MMU use field of the full set |
| vm_on | input | 1 | Status: virtual mode enabled |
| lu_hit | input | 1 | Lookup succeeded |
| lu_err_prot | input | 1 | On a failed lookup: 1 protection fault, 0 miss |
| lu_vbase | input | AW | Matched entry virtual base |
| lu_pbase | input | AW | Matched entry physical base |
| exc_ack | input | 1 | Exception controller takes the pending request |
| paddr | output | AW | Physical address |
| full_perm | output | 1 | Identity map with full permissions |
| xlat_ok | output | 1 | Valid access that did not fault |
| syndrome | output | SW | Captured exception syndrome |
| ear | output | AW | Captured faulting virtual address |
| exc_req | output | 1 | MMU exception pending |
| recursive | output | 1 | Pulse: fault while an MMU exception was pending |

## Verification
The hardest case to reach is a recursive fault, because it needs a second failed lookup while an earlier exception is still unacknowledged. The same applies to the edge where an acknowledge and a new fault land together. The stimulus holds `exc_ack` low across two consecutive faults that differ in address and in kind. It then repeats the pattern with the acknowledge and the fault in the same cycle. This shows that the first capture survives in both cases and that the request drops only when nothing new is taken.

// File: rtl/mmu_fault_syndrome.sv
module mmu_fault_syndrome #(
  parameter int AW = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] vaddr,
  input  logic [1:0]    acc,
  input  logic          cfg_mmu_present,
  input  logic          cfg_full,
  input  logic          cfg_mmu_used,
  input  logic          vm_on,
  input  logic          lu_hit,
  input  logic          lu_err_prot,
  input  logic [AW-1:0] lu_vbase,
  input  logic [AW-1:0] lu_pbase,
  input  logic          exc_ack,
  output logic [AW-1:0] paddr,
  output logic          full_perm,
  output logic          xlat_ok,
  output logic [SW-1:0] syndrome,
  output logic [AW-1:0] ear,
  output logic          exc_req,
  output logic          recursive
);
  localparam int OFFW = $clog2(PAGE_BYTES);
  localparam logic [AW-1:0] OFF_MASK = AW'(PAGE_BYTES - 1);

  logic          active, fault, is_fetch, is_store;
  logic [AW-1:0] vpage, xbase;
  logic [SW-1:0] code;

  assign active   = cfg_mmu_present & vm_on & (~cfg_full | cfg_mmu_used);
  assign fault    = req_valid & active & ~lu_hit;
  assign is_fetch = (acc == 2'd2);
  assign is_store = (acc == 2'd1);

  assign vpage = vaddr & ~OFF_MASK;
  assign xbase = lu_pbase + vpage - lu_vbase;

  always_comb begin
    if (!active)     paddr = vaddr;
    else if (lu_hit) paddr = (xbase & ~OFF_MASK) | (vaddr & OFF_MASK);
    else             paddr = '0;
  end

  assign full_perm = ~active;
  assign xlat_ok   = req_valid & ~fault;

  always_comb begin
    code = '0;
    code[4] = 1'b1;
    code[1] = ~lu_err_prot;
    code[0] = is_fetch;
    code[10] = is_store;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syndrome  <= '0;
      ear       <= '0;
      exc_req   <= 1'b0;
      recursive <= 1'b0;
    end else begin
      recursive <= fault & exc_req;
      if (fault && !exc_req) begin
        syndrome <= code;
        ear      <= vaddr;
        exc_req  <= 1'b1;
      end else if (exc_ack) begin
        exc_req  <= 1'b0;
      end
    end
  end

  p_bypass_ident_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_mmu_present && vm_on) |-> (paddr == vaddr) && full_perm);

  p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_ok |-> paddr[OFFW-1:0] == vaddr[OFFW-1:0]);

  p_fault_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !lu_hit && !exc_req && !full_perm) |=> exc_req && (ear == $past(vaddr)));

  p_syn_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (syndrome[9:5] == '0) && (syndrome[4:2] == 3'b100) && (syndrome[SW-1:11] == '0));

  p_recursive_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> $stable(syndrome) && $stable(ear));

  p_recursive_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_req && req_valid && !lu_hit && !full_perm) |=> recursive);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !exc_req) |=> !exc_req && !recursive);
endmodule

// File: tb/mmu_fault_syndrome_bench.sv
module mmu_fault_syndrome_bench;
  localparam int AW = 32;
  localparam int SW = 16;
  localparam logic [AW-1:0] OM = 32'hFFF;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, cfg_mmu_present = 0, cfg_full = 0, cfg_mmu_used = 0, vm_on = 0;
  logic lu_hit = 0, lu_err_prot = 0, exc_ack = 0;
  logic [1:0] acc = 0;
  logic [AW-1:0] vaddr = 0, lu_vbase = 0, lu_pbase = 0;
  logic [AW-1:0] paddr, ear;
  logic [SW-1:0] syndrome;
  logic full_perm, xlat_ok, exc_req, recursive;

  always #2 clk = ~clk;

  mmu_fault_syndrome u_mmu_fault_syndrome (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vaddr(vaddr), .acc(acc),
    .cfg_mmu_present(cfg_mmu_present), .cfg_full(cfg_full), .cfg_mmu_used(cfg_mmu_used),
    .vm_on(vm_on), .lu_hit(lu_hit), .lu_err_prot(lu_err_prot), .lu_vbase(lu_vbase),
    .lu_pbase(lu_pbase), .exc_ack(exc_ack), .paddr(paddr), .full_perm(full_perm),
    .xlat_ok(xlat_ok), .syndrome(syndrome), .ear(ear), .exc_req(exc_req), .recursive(recursive));

  typedef struct {
    string tag;
    logic chk_pa;
    logic [AW-1:0] pa;
    logic perm, ok;
    logic [SW-1:0] syn;
    logic [AW-1:0] ea;
    logic exc, rec;
  } item_t;

  item_t q[$];
  int compared = 0, mismatched = 0;
  logic m_exc = 0, done = 0;
  logic [SW-1:0] m_syn = 0;
  logic [AW-1:0] m_ear = 0;

  task automatic cmp(string tag, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic rv, logic [AW-1:0] va, logic [1:0] at,
                      logic pres, logic full, logic used, logic vm, logic hit, logic prot,
                      logic [AW-1:0] vb, logic [AW-1:0] pb, logic ack);
    item_t it;
    logic act, flt;
    @(negedge clk);
    req_valid = rv; vaddr = va; acc = at; cfg_mmu_present = pres; cfg_full = full;
    cfg_mmu_used = used; vm_on = vm; lu_hit = hit; lu_err_prot = prot;
    lu_vbase = vb; lu_pbase = pb; exc_ack = ack;
    act = pres && vm && (!full || used);
    flt = rv && act && !hit;
    it.tag = tag;
    it.perm = !act;
    it.ok = rv && !flt;
    it.chk_pa = !act || hit;
    it.pa = !act ? va : (((pb + (va & ~OM) - vb) & ~OM) | (va & OM));
    it.rec = flt && m_exc;
    if (flt && !m_exc) begin
      m_syn = SW'(16) | SW'(prot ? 0 : 2) | SW'(at == 2'd2) | (SW'(at == 2'd1) << 10);
      m_ear = va;
      m_exc = 1;
    end else if (ack) m_exc = 0;
    it.syn = m_syn; it.ea = m_ear; it.exc = m_exc;
    q.push_back(it);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        if (it.chk_pa) cmp(it.tag, "paddr", paddr, it.pa);
        cmp(it.tag, "full_perm", AW'(full_perm), AW'(it.perm));
        cmp(it.tag, "xlat_ok", AW'(xlat_ok), AW'(it.ok));
        cmp(it.tag, "syndrome", AW'(syndrome), AW'(it.syn));
        cmp(it.tag, "ear", ear, it.ea);
        cmp(it.tag, "exc_req", AW'(exc_req), AW'(it.exc));
        cmp(it.tag, "recursive", AW'(recursive), AW'(it.rec));
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R10", "syndrome", AW'(syndrome), 0);
    cmp("R10", "ear", ear, 0);
    cmp("R10", "exc_req", AW'(exc_req), 0);
    cmp("R10", "recursive", AW'(recursive), 0);
    rst_n = 1;
    // R1/R2: each inactive configuration bypasses, even with a failed lookup
    step("R2 vm off", 1, 32'h1234_5678, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R1 not present", 1, 32'h0000_0ABC, 1, 0, 0, 0, 1, 0, 1, 0, 0, 0);
    step("R1 full unused", 1, 32'hDEAD_BEEF, 2, 1, 1, 0, 1, 0, 0, 0, 0, 0);
    // R3/R4: hits
    step("R3 hit", 1, 32'h4000_3ABC, 0, 1, 0, 0, 1, 1, 0, 32'h4000_0000, 32'h0010_0000, 0);
    step("R3 hit full used", 1, 32'h8001_2FFF, 2, 1, 1, 1, 1, 1, 0, 32'h8000_0000, 32'hC000_5000, 0);
    step("R4 hit wrap", 1, 32'h0000_1001, 1, 1, 0, 0, 1, 1, 0, 32'h0000_3000, 32'h0000_1000, 0);
    // R11: failed lookup without a request
    step("R11 idle", 0, 32'h5555_5000, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0);
    // R5/R6/R7: prot load, then ack
    step("R6 prot load", 1, 32'h1111_2222, 0, 1, 0, 0, 1, 0, 1, 0, 0, 0);
    step("R9 ack", 0, 0, 0, 1, 0, 0, 1, 0, 0, 0, 0, 1);
    step("R6 prot fetch", 1, 32'h2222_3334, 2, 1, 0, 0, 1, 0, 1, 0, 0, 0);
    step("R9 ack", 0, 0, 0, 1, 0, 0, 1, 0, 0, 0, 0, 1);
    step("R7 miss store", 1, 32'h3333_4448, 1, 1, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R9 ack", 0, 0, 0, 1, 0, 0, 1, 0, 0, 0, 0, 1);
    step("R6 miss fetch", 1, 32'h4444_5550, 2, 1, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R9 ack", 0, 0, 0, 1, 0, 0, 1, 0, 0, 0, 0, 1);
    step("R7 acc3 prot", 1, 32'h5555_6660, 3, 1, 0, 0, 1, 0, 1, 0, 0, 0);
    // R8: second fault while pending, then fault with ack in same cycle
    step("R8 recursive", 1, 32'h6666_7770, 1, 1, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R8 hold", 0, 0, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R8 fault+ack", 1, 32'h7777_8880, 2, 1, 0, 0, 1, 0, 1, 0, 0, 1);
    step("R5 refault", 1, 32'h8888_9990, 2, 1, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R11 idle pend", 0, 32'h9999_0000, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R9 ack", 0, 0, 0, 1, 0, 0, 1, 0, 0, 0, 0, 1);
    step("R2 drain", 0, 32'h0000_0010, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (2) @(posedge clk);
    #2;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule